// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block sits beside a small CPU core and decides which of thirteen interrupt sources the core should service next. Sources 0 and 1 come from two active-low external pins. Each pin can be set to level mode, where the request follows the pin, or to edge mode, where a falling edge sets a sticky flag. Sources 2 to 12 are level request lines from on-chip peripherals. Every source has its own enable bit. A global enable gates all of them. A priority level from 0 to 3 is built from one bit of a low-priority register and one bit of a high-priority register.

At each instruction-boundary strobe the controller picks the winner and registers a request, a vector index and the winner's level. The highest level wins. Within one level, the lowest source index wins. A 4-bit in-service vector, one bit per level, records which levels have routines in progress. A new request is raised only when its level is strictly above every level in service. The CPU's acknowledge sets the bit for the granted level. Its return-from-interrupt pulse clears the highest bit that is set. A combinational wake output reports any enabled pending source so that the core can leave idle or power-down.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, irq_req is 0, irq_vec is 0 and wake is 0 while both pins are high and no peripheral request is set.
- R2: While the global enable is 0, an instruction boundary leaves irq_req at 0, whatever the pending requests are.
- R3: A source whose enable bit is 0 never wins arbitration.
- R4: A source's level is {hi_bit, lo_bit}, with the high-priority register supplying bit 1. Among eligible sources the one with the greatest level wins, whatever its index.
- R5: Among eligible sources at the same level, the lowest source index wins. Index 0 is pin 0, index 1 is pin 1, and index k+2 is periph_req[k].
- R6: A request is raised only if its level is strictly higher than the highest level in service. A request at the same level or lower is held off. An acknowledge while irq_req is 1 marks irq_lvl as in service.
- R7: While level 3 is in service, no instruction boundary raises irq_req.
- R8: A reti pulse removes only the highest in-service level, so a request held off by that level can then be granted.
- R9: In edge mode (mode bit 1), a high-to-low transition between two clock samples of a pin sets a flag. The flag stays set after the pin returns high and is cleared by the acknowledge of that source.
- R10: In level mode (mode bit 0), a pin requests while it is low. The request is not latched and goes away when the pin returns high.
- R11: wake is 1 whenever any individually enabled source is pending. This holds even when the global enable is 0 and whatever levels are in service.
- R12: irq_req, irq_vec and irq_lvl change only at an instruction boundary or an acknowledge. An acknowledge while irq_req is 1 clears irq_req on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| periph_req | input | 11 | Peripheral request lines, sources 2..12 |
| en_we | input | 1 | Write strobe for the per-source enable register |
| en_wdata | input | 13 | Per-source enable bits |
| gen_we | input | 1 | Write strobe for the global enable |
| gen_wdata | input | 1 | Global enable value |
| plo_we | input | 1 | Write strobe for the low priority register |
| plo_wdata | input | 13 | Priority bit 0 per source |
| phi_we | input | 1 | Write strobe for the high priority register |
| phi_wdata | input | 13 | Priority bit 1 per source |
| mode_we | input | 1 | Write strobe for the pin trigger modes |
| mode_wdata | input | 2 | 1 = edge mode, 0 = level mode, per pin |
| insn_boundary | input | 1 | Instruction-boundary strobe; arbitration is sampled here |
| ack | input | 1 | CPU acknowledge of the registered request |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 4 | Index of the requesting source |
| irq_lvl | output | 2 | Level of the requesting source |
| wake | output | 1 | Wake-up indication for idle or power-down |

## Verification
Four properties are checked on every cycle. The outputs hold steady between strobes. An acknowledge clears the request and marks its level in service. A reti removes exactly one in-service level. Any raised request sits strictly above every level in service, and a clear global enable or level 3 in service blocks any new request. Other behaviour is visible only through the bench's scenarios: which source wins among mixed levels and equal-level ties, masking by an individual enable, latching versus following on the pins, and wake while the global enable is off. The scenarios also walk a three-deep nesting up and back down.

// File: rtl/irq_pkg.sv
// Package: shared sizes for the priority interrupt controller.
// Assumes two priority bits per source, so the level count is fixed at four.
package irq_pkg;
    localparam int IRQ_NSRC = 13;
    localparam int IRQ_NEXT = 2;
    localparam int IRQ_NLVL = 4;
    localparam int IRQ_LW   = $clog2(IRQ_NLVL);
    localparam int IRQ_VW   = $clog2(IRQ_NSRC);
endpackage

// File: rtl/irq_ext_trig.sv
// Module: irq_ext_trig
// Turns active-low external pins into request bits. In level mode a bit
// follows the inverted pin. In edge mode a falling edge between two clock
// samples sets a sticky flag, which clr removes. Assumes the pins are
// already synchronised to clk.
module irq_ext_trig #(
    parameter int NEXT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] pin_n,
    input  logic [NEXT-1:0] mode_edge,
    input  logic [NEXT-1:0] clr,
    output logic [NEXT-1:0] pend
);
    genvar g;
    generate
        for (g = 0; g < NEXT; g++) begin : g_pin
            logic prev_q;
            logic flag_q;

            // Holds the previous pin sample for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b1;
                else        prev_q <= pin_n[g];
            end

            // Edge flag: a set wins over a clear in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)                     flag_q <= 1'b0;
                else if (prev_q && !pin_n[g])   flag_q <= 1'b1;
                else if (clr[g])                flag_q <= 1'b0;
            end

            // Chooses the request source for this pin by its mode.
            assign pend[g] = mode_edge[g] ? flag_q : ~pin_n[g];
        end
    endgenerate
endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Combinational winner selection. Among the candidate sources it takes the
// highest level, breaking ties by the lowest index. It grants only when that
// level lies strictly above every level marked in service. Assumes cand is
// already gated by the individual and global enables.
module irq_arbiter #(
    parameter int NSRC = 13,
    parameter int NLVL = 4,
    localparam int LW  = $clog2(NLVL),
    localparam int VW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] cand,
    input  logic [NSRC-1:0] plo,
    input  logic [NSRC-1:0] phi,
    input  logic [NLVL-1:0] isr,
    output logic            grant,
    output logic [VW-1:0]   win_idx,
    output logic [LW-1:0]   win_lvl
);
    logic          best_f;
    logic [LW:0]   floor_v;
    logic [LW-1:0] lvl_i;

    // Scans from the top index down, so at equal level the lower index replaces the current best.
    always_comb begin
        best_f  = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        lvl_i   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            lvl_i = {phi[i], plo[i]};
            if (cand[i] && (!best_f || lvl_i >= win_lvl)) begin
                best_f  = 1'b1;
                win_idx = VW'(i);
                win_lvl = lvl_i;
            end
        end
    end

    // Finds the lowest level a new request must reach: one above the top in-service level.
    always_comb begin
        floor_v = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (isr[l]) floor_v = (LW + 1)'(l + 1);
        end
    end

    assign grant = best_f && ({1'b0, win_lvl} >= floor_v);
endmodule

// File: rtl/irq_inservice.sv
// Module: irq_inservice
// Keeps one in-service bit per priority level. push sets the bit for
// push_lvl. pop clears the highest set bit. With both in one cycle, the pop
// acts on the old state and the push is applied after it.
module irq_inservice #(
    parameter int NLVL = 4,
    localparam int LW  = $clog2(NLVL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [LW-1:0]   push_lvl,
    input  logic            pop,
    output logic [NLVL-1:0] isr
);
    logic [NLVL-1:0] top_mask;
    logic [NLVL-1:0] nxt;

    // Builds a one-hot mask of the highest set in-service bit.
    always_comb begin
        top_mask = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (isr[l]) top_mask = NLVL'(1) << l;
        end
    end

    // Applies the pop first and the push after it.
    always_comb begin
        nxt = isr;
        if (pop)  nxt = nxt & ~top_mask;
        if (push) nxt = nxt | (NLVL'(1) << push_lvl);
    end

    // In-service register.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= nxt;
    end
endmodule

// File: rtl/irq_ctrl.sv
// Module: irq_ctrl (top)
// Four-level priority interrupt controller. It holds the enable, priority
// and trigger-mode registers, forms the pending vector, and registers the
// arbitration result at each instruction boundary. It also tracks in-service
// levels and drives wake. Assumes ack is pulsed only when the CPU takes
// irq_req, and reti once per finished routine.
module irq_ctrl #(
    parameter int NSRC = irq_pkg::IRQ_NSRC,
    parameter int NEXT = irq_pkg::IRQ_NEXT,
    parameter int NLVL = irq_pkg::IRQ_NLVL,
    localparam int LW  = $clog2(NLVL),
    localparam int VW  = $clog2(NSRC),
    localparam int NPER = NSRC - NEXT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] ext_pin_n,
    input  logic [NPER-1:0] periph_req,
    input  logic            en_we,
    input  logic [NSRC-1:0] en_wdata,
    input  logic            gen_we,
    input  logic            gen_wdata,
    input  logic            plo_we,
    input  logic [NSRC-1:0] plo_wdata,
    input  logic            phi_we,
    input  logic [NSRC-1:0] phi_wdata,
    input  logic            mode_we,
    input  logic [NEXT-1:0] mode_wdata,
    input  logic            insn_boundary,
    input  logic            ack,
    input  logic            reti,
    output logic            irq_req,
    output logic [VW-1:0]   irq_vec,
    output logic [LW-1:0]   irq_lvl,
    output logic            wake
);
    logic [NSRC-1:0] en_q;
    logic            gen_q;
    logic [NSRC-1:0] plo_q;
    logic [NSRC-1:0] phi_q;
    logic [NEXT-1:0] mode_q;
    logic [NEXT-1:0] ext_pend;
    logic [NEXT-1:0] ext_clr;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] cand;
    logic [NLVL-1:0] isr;
    logic            grant;
    logic [VW-1:0]   win_idx;
    logic [LW-1:0]   win_lvl;
    logic            ack_ok;

    // Configuration registers, written through their own strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            gen_q  <= 1'b0;
            plo_q  <= '0;
            phi_q  <= '0;
            mode_q <= '0;
        end else begin
            if (en_we)   en_q   <= en_wdata;
            if (gen_we)  gen_q  <= gen_wdata;
            if (plo_we)  plo_q  <= plo_wdata;
            if (phi_we)  phi_q  <= phi_wdata;
            if (mode_we) mode_q <= mode_wdata;
        end
    end

    assign ack_ok = ack && irq_req;

    // Acknowledge clears the edge flag of the granted pin only.
    genvar g;
    generate
        for (g = 0; g < NEXT; g++) begin : g_clr
            assign ext_clr[g] = ack_ok && (irq_vec == VW'(g));
        end
    endgenerate

    irq_ext_trig #(.NEXT(NEXT)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (ext_pin_n),
        .mode_edge (mode_q),
        .clr       (ext_clr),
        .pend      (ext_pend)
    );

    assign pend = {periph_req, ext_pend};
    assign cand = pend & en_q & {NSRC{gen_q}};
    assign wake = |(pend & en_q);

    irq_arbiter #(.NSRC(NSRC), .NLVL(NLVL)) u_arb (
        .cand    (cand),
        .plo     (plo_q),
        .phi     (phi_q),
        .isr     (isr),
        .grant   (grant),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    irq_inservice #(.NLVL(NLVL)) u_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_ok),
        .push_lvl (irq_lvl),
        .pop      (reti),
        .isr      (isr)
    );

    // Registers the decision at a boundary. An acknowledge takes precedence and drops the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
            irq_lvl <= '0;
        end else if (ack_ok) begin
            irq_req <= 1'b0;
        end else if (insn_boundary) begin
            irq_req <= grant;
            irq_vec <= win_idx;
            irq_lvl <= win_lvl;
        end
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
// Module: irq_ctrl_chk
// Cycle-by-cycle properties of irq_ctrl, attached by bind below.
module irq_ctrl_chk #(
    parameter int NSRC = 13,
    parameter int NLVL = 4,
    localparam int LW  = $clog2(NLVL),
    localparam int VW  = $clog2(NSRC)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            insn_boundary,
    input logic            ack,
    input logic            reti,
    input logic            irq_req,
    input logic [VW-1:0]   irq_vec,
    input logic [LW-1:0]   irq_lvl,
    input logic            gen_q,
    input logic [NLVL-1:0] isr
);
    // R12: outputs move only at a boundary or an acknowledge.
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_boundary && !ack) |=> ($stable(irq_req) && $stable(irq_vec) && $stable(irq_lvl)));

    // R12: an accepted acknowledge drops the request.
    p_ack_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> !irq_req);

    // R6: an accepted acknowledge marks the granted level in service.
    p_ack_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> isr[$past(irq_lvl)]);

    // R2: a clear global enable blocks every grant.
    p_global_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_boundary && !gen_q) |=> !irq_req);

    // R7: level 3 in service blocks every grant.
    p_top_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_boundary && isr[NLVL-1]) |=> !irq_req);

    // R6: a raised request lies strictly above all in-service levels.
    p_strict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ((isr >> irq_lvl) == '0));

    // R8: reti removes exactly one in-service level.
    p_reti_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !(ack && irq_req) && (isr != '0)) |=> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

bind irq_ctrl irq_ctrl_chk #(.NSRC(NSRC), .NLVL(NLVL)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_boundary (insn_boundary),
    .ack           (ack),
    .reti          (reti),
    .irq_req       (irq_req),
    .irq_vec       (irq_vec),
    .irq_lvl       (irq_lvl),
    .gen_q         (gen_q),
    .isr           (isr)
);

// File: tb/sim_irq_ctrl.sv
// Scoreboard bench for irq_ctrl. A driver task queues the expected result
// of each instruction boundary, and a monitor compares one cycle later.
module sim_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [10:0] periph_req = '0;
    logic        en_we = 0, gen_we = 0, plo_we = 0, phi_we = 0, mode_we = 0;
    logic [12:0] en_wdata = '0, plo_wdata = '0, phi_wdata = '0;
    logic        gen_wdata = 0;
    logic [1:0]  mode_wdata = '0;
    logic        insn_boundary = 0, ack = 0, reti = 0;
    logic        irq_req, wake;
    logic [3:0]  irq_vec;
    logic [1:0]  irq_lvl;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        bit    req;
        int    vec;
        int    lvl;
        string tag;
    } exp_t;
    exp_t sb[$];
    logic bnd_seen = 0;

    always #5 clk = ~clk;

    irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .periph_req(periph_req),
        .en_we(en_we), .en_wdata(en_wdata), .gen_we(gen_we), .gen_wdata(gen_wdata),
        .plo_we(plo_we), .plo_wdata(plo_wdata), .phi_we(phi_we), .phi_wdata(phi_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .insn_boundary(insn_boundary),
        .ack(ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_lvl(irq_lvl), .wake(wake)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: pulses a boundary and queues the expected registered result.
    task automatic boundary(input bit req, input int vec, input int lvl, input string tag);
        exp_t e;
        @(negedge clk);
        e.req = req; e.vec = vec; e.lvl = lvl; e.tag = tag;
        sb.push_back(e);
        insn_boundary = 1;
        @(negedge clk);
        insn_boundary = 0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1;
        @(negedge clk); reti = 0;
    endtask

    task automatic wr_en(input logic [12:0] d);
        @(negedge clk); en_we = 1; en_wdata = d;
        @(negedge clk); en_we = 0;
    endtask
    task automatic wr_gen(input logic d);
        @(negedge clk); gen_we = 1; gen_wdata = d;
        @(negedge clk); gen_we = 0;
    endtask
    task automatic wr_prio(input logic [12:0] lo, input logic [12:0] hi);
        @(negedge clk); plo_we = 1; plo_wdata = lo; phi_we = 1; phi_wdata = hi;
        @(negedge clk); plo_we = 0; phi_we = 0;
    endtask
    task automatic wr_mode(input logic [1:0] d);
        @(negedge clk); mode_we = 1; mode_wdata = d;
        @(negedge clk); mode_we = 0;
    endtask

    // Monitor: marks the cycle after a boundary edge.
    always @(posedge clk) bnd_seen <= insn_boundary;

    // Monitor: pops and compares the result registered at that boundary.
    always @(negedge clk) begin
        if (bnd_seen && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " req"}, int'(irq_req), int'(e.req));
            if (e.req) begin
                check({e.tag, " vec"}, int'(irq_vec), e.vec);
                check({e.tag, " lvl"}, int'(irq_lvl), e.lvl);
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 req", int'(irq_req), 0);
        check("R1 vec", int'(irq_vec), 0);
        check("R1 wake", int'(wake), 0);

        wr_en(13'h1FFF);
        wr_prio('0, '0);
        wr_mode(2'b00);
        wr_gen(1'b0);

        // Source 5 is pending while the global enable is off.
        @(negedge clk); periph_req[3] = 1;
        @(negedge clk);
        check("R11 wake with global off", int'(wake), 1);
        boundary(0, 0, 0, "R2 global off");

        wr_gen(1'b1);
        @(negedge clk); periph_req[7] = 1;          // source 9
        boundary(1, 5, 0, "R5 tie lowest index");

        wr_prio('0, 13'h0200);                      // source 9 -> level 2
        boundary(1, 9, 2, "R4 higher level wins");

        wr_en(13'h1DFF);                            // source 9 disabled
        boundary(1, 5, 0, "R3 disabled source ignored");
        wr_en(13'h1FFF);

        // Nesting: src4 L1, src9 L2, src12 L3.
        @(negedge clk); periph_req = '0;
        wr_prio(13'h1010, 13'h1200);
        @(negedge clk); periph_req[2] = 1;
        boundary(1, 4, 1, "R6 first grant");
        pulse_ack();
        @(negedge clk);
        check("R12 ack drops req", int'(irq_req), 0);
        boundary(0, 0, 0, "R6 same level held");

        @(negedge clk); periph_req[7] = 1;
        boundary(1, 9, 2, "R6 higher preempts");
        pulse_ack();
        @(negedge clk); periph_req[10] = 1;
        boundary(1, 12, 3, "R4 level3 wins");
        pulse_ack();
        boundary(0, 0, 0, "R7 top level blocks");

        @(negedge clk); periph_req[10] = 0;
        pulse_reti();
        boundary(0, 0, 0, "R8 level2 still in service");
        pulse_reti();
        boundary(1, 9, 2, "R8 granted after reti");
        pulse_reti();
        pulse_reti();
        @(negedge clk); periph_req = '0;
        boundary(0, 0, 0, "R8 idle after unwind");

        // Edge mode on pin 0.
        wr_prio('0, '0);
        wr_mode(2'b01);
        @(negedge clk); ext_pin_n[0] = 0;
        @(negedge clk); ext_pin_n[0] = 1;
        @(negedge clk);
        boundary(1, 0, 0, "R9 edge latched");
        boundary(1, 0, 0, "R9 flag persists");
        pulse_ack();
        pulse_reti();
        boundary(0, 0, 0, "R9 flag cleared by ack");
        @(negedge clk);
        check("R11 wake idle", int'(wake), 0);

        // Level mode on pin 1.
        @(negedge clk); ext_pin_n[1] = 0;
        boundary(1, 1, 0, "R10 level request");
        repeat (3) @(negedge clk);
        check("R12 req held", int'(irq_req), 1);
        check("R12 vec held", int'(irq_vec), 1);
        ext_pin_n[1] = 1;
        boundary(0, 0, 0, "R10 not latched");

        repeat (3) @(negedge clk);
        check("scoreboard drained", sb.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule